// File: doc/BRIEF.md
# Tagged Transmit FIFO Loader

This block sits between a processor-style register port and the write side of an HDLC transmit FIFO. Each data byte the processor writes becomes one 10-bit FIFO entry: the byte itself plus two tag bits. One tag marks the last byte of a packet and the other asks the transmitter to send an abort instead of that byte. The block assembles the entry, pushes it toward the FIFO one cycle later, and raises a sticky overflow flag when a write arrives while the FIFO reports full.

The tags are never supplied with the data word. Software sets them in advance through control bits that clear themselves once a byte has been accepted. The end-of-packet tag can also come from a length counter. Software loads the counter with the packet length, and the block then marks the final byte of every packet on its own. With the repeat bit set, the counter reloads the same length after each mark, so a stream of equal-length packets needs a single setup write.

Top module: `tfl_loader`

## Requirements
- R1: After a synchronous reset, `push_vld`, `push_entry` and `overflow` are 0. The manual tags, the repeat bit, the stored length and the count are all 0.
- R2: A data write (`dat_we`) while `fifo_full` is low is accepted. On the next cycle `push_vld` is 1 and `push_entry` is {abort bit 9, end-of-packet bit 8, data bits 7:0}. In any cycle with no accepted write on the previous edge, `push_vld` is 0 and `push_entry` is 0.
- R3: A register write with `reg_addr`=0 sets the manual end-of-packet tag from bit 0, the manual abort tag from bit 1 and the repeat bit from bit 2. The manual tags are copied into the next accepted entry and then clear. The repeat bit is sticky.
- R4: A register write with `reg_addr`=1 loads both the stored length and the count from `reg_wdata[15:0]`. Each accepted write decrements a non-zero count, and the write made while the count is 1 is tagged end-of-packet.
- R5: When a tag is generated with the repeat bit set, the count reloads the stored length. With the repeat bit clear, the count goes to 0 and generates no further tags until it is reloaded.
- R6: A count of 0, whether loaded or reached, produces no automatic tag and stays at 0.
- R7: The end-of-packet bit of an entry is the OR of the manual tag and the counter-generated tag.
- R8: A data write while `fifo_full` is high is dropped. There is no push, and the tags and the count are unchanged. `overflow` is set and stays set until a control write with bit 3 = 1 clears it. A set in the same cycle as a clear wins.
- R9: When a register write and an accepted data write fall in the same cycle, the entry uses the values held before that cycle. The register write then overrides the self-clear of the tags and the decrement or reload of the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control bits, 1 = packet length |
| reg_wdata | input | 16 | Register write data |
| dat_we | input | 1 | FIFO data write strobe |
| dat_byte | input | 8 | Data byte to enqueue |
| fifo_full | input | 1 | FIFO cannot accept an entry |
| push_vld | output | 1 | Entry push toward the FIFO |
| push_entry | output | 10 | {abort, end-of-packet, data} |
| overflow | output | 1 | Sticky: a write was dropped while full |

## Verification
The bench targets the byte written while the count is 1, with the repeat bit both set and clear. A design with an off-by-one in the counter tags the wrong byte, and one that ignores the repeat bit keeps tagging or stops too early. It also writes while the FIFO is full and checks that the pending tags and the count survive. A design that consumed state on a dropped write would lose a packet boundary that shows up on a later byte. Same-cycle register and data writes expose a wrong priority as a tag landing one byte early or vanishing. A length of 0 and a length of 1 cover the counter's two edge values.

// File: rtl/tfl_pkg.sv
package tfl_pkg;
  typedef enum logic {
    ADDR_CTRL  = 1'b0,
    ADDR_COUNT = 1'b1
  } reg_addr_e;

  localparam int CTL_EOP_BIT = 0;
  localparam int CTL_ABT_BIT = 1;
  localparam int CTL_RPT_BIT = 2;
  localparam int CTL_OVC_BIT = 3;

  typedef struct packed {
    logic abort;
    logic eop;
  } tag_t;
endpackage

// File: rtl/tfl_tag_regs.sv
module tfl_tag_regs
  import tfl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ctl_we,
  input  logic ctl_eop,
  input  logic ctl_abt,
  input  logic ctl_rpt,
  input  logic accept,
  output tag_t man_tag,
  output logic rpt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      man_tag <= '0;
      rpt     <= 1'b0;
    end else begin
      if (accept) begin
        man_tag <= '0;
      end
      if (ctl_we) begin
        man_tag.eop   <= ctl_eop;
        man_tag.abort <= ctl_abt;
        rpt           <= ctl_rpt;
      end
    end
  end
endmodule

// File: rtl/tfl_len_counter.sv
module tfl_len_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             accept,
  input  logic             rpt,
  output logic             auto_eop
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_step;

  assign auto_eop = (cnt_q == CNT_ONE);

  always_comb begin
    cnt_step = cnt_q;
    if (cnt_q == CNT_ONE) begin
      cnt_step = rpt ? len_q : '0;
    end else if (cnt_q != '0) begin
      cnt_step = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      len_q <= load_val;
      cnt_q <= load_val;
    end else if (accept) begin
      cnt_q <= cnt_step;
    end
  end
endmodule

// File: rtl/tfl_push_stage.sv
module tfl_push_stage
  import tfl_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ENT_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] data,
  input  tag_t              tag,
  output logic              push_vld,
  output logic [ENT_W-1:0]  push_entry
);
  always_ff @(posedge clk) begin
    if (rst) begin
      push_vld   <= 1'b0;
      push_entry <= '0;
    end else begin
      push_vld   <= accept;
      push_entry <= accept ? {tag.abort, tag.eop, data} : '0;
    end
  end
endmodule

// File: rtl/tfl_loader.sv
module tfl_loader
  import tfl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 16,
  localparam int ENT_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] dat_byte,
  input  logic              fifo_full,
  output logic              push_vld,
  output logic [ENT_W-1:0]  push_entry,
  output logic              overflow
);
  logic accept;
  logic drop;
  logic ctl_we;
  logic cnt_we;
  logic rpt;
  logic auto_eop;
  tag_t man_tag;
  tag_t ent_tag;

  assign accept = dat_we & ~fifo_full;
  assign drop   = dat_we & fifo_full;
  assign ctl_we = reg_we & (reg_addr == ADDR_CTRL);
  assign cnt_we = reg_we & (reg_addr == ADDR_COUNT);

  tfl_tag_regs u_tags (
    .clk     (clk),
    .rst     (rst),
    .ctl_we  (ctl_we),
    .ctl_eop (reg_wdata[CTL_EOP_BIT]),
    .ctl_abt (reg_wdata[CTL_ABT_BIT]),
    .ctl_rpt (reg_wdata[CTL_RPT_BIT]),
    .accept  (accept),
    .man_tag (man_tag),
    .rpt     (rpt)
  );

  tfl_len_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_we),
    .load_val (reg_wdata[CNT_W-1:0]),
    .accept   (accept),
    .rpt      (rpt),
    .auto_eop (auto_eop)
  );

  always_comb begin
    ent_tag.abort = man_tag.abort;
    ent_tag.eop   = man_tag.eop | auto_eop;
  end

  tfl_push_stage #(.DATA_W(DATA_W)) u_push (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .data       (dat_byte),
    .tag        (ent_tag),
    .push_vld   (push_vld),
    .push_entry (push_entry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow <= 1'b0;
    end else if (drop) begin
      overflow <= 1'b1;
    end else if (ctl_we && reg_wdata[CTL_OVC_BIT]) begin
      overflow <= 1'b0;
    end
  end
endmodule

// File: rtl/tfl_loader_chk.sv
module tfl_loader_chk #(
  parameter int DATA_W = 8,
  parameter int REG_W  = 16,
  localparam int ENT_W = DATA_W + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic              reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              dat_we,
  input logic              fifo_full,
  input logic              push_vld,
  input logic [ENT_W-1:0]  push_entry,
  input logic              overflow
);
  logic ovf_clear;
  assign ovf_clear = reg_we && (reg_addr == 1'b0) && reg_wdata[3];

  assert_push_from_write_R2: assert property (@(posedge clk) disable iff (rst)
    push_vld |-> $past(dat_we && !fifo_full));

  assert_write_pushes_R2: assert property (@(posedge clk) disable iff (rst)
    (dat_we && !fifo_full) |=> push_vld);

  assert_idle_entry_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !push_vld |-> (push_entry == '0));

  assert_full_drops_R8: assert property (@(posedge clk) disable iff (rst)
    (dat_we && fifo_full) |=> (!push_vld && overflow));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (overflow && !ovf_clear) |=> overflow);

  assert_ovf_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(dat_we && fifo_full));
endmodule

bind tfl_loader tfl_loader_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .dat_we     (dat_we),
  .fifo_full  (fifo_full),
  .push_vld   (push_vld),
  .push_entry (push_entry),
  .overflow   (overflow)
);

// File: tb/tfl_loader_tb.sv
`timescale 1ns/1ps
module tfl_loader_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        dat_we = 1'b0;
  logic [7:0]  dat_byte = '0;
  logic        fifo_full = 1'b0;
  logic        push_vld;
  logic [9:0]  push_entry;
  logic        overflow;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  bit          m_eop = 0, m_abt = 0, m_rpt = 0, m_ovf = 0;
  int unsigned m_len = 0, m_cnt = 0;

  always #2.5 clk = ~clk;

  tfl_loader u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dat_we(dat_we), .dat_byte(dat_byte),
    .fifo_full(fifo_full), .push_vld(push_vld), .push_entry(push_entry),
    .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_entry(input bit acc, input bit abt, input bit eop,
                                   input int unsigned cnt, input logic [7:0] d);
    if (!acc) return 0;
    return {22'd0, abt, eop | (cnt == 1), d};
  endfunction

  // one cycle of stimulus; called at a negedge, returns at the next negedge
  task automatic op(input bit rwe, input bit radr, input logic [15:0] rval,
                    input bit dwe, input logic [7:0] d, input bit full,
                    input string req);
    bit acc;
    int ee;
    acc = dwe && !full;
    ee = exp_entry(acc, m_abt, m_eop, m_cnt, d);
    reg_we = rwe; reg_addr = radr; reg_wdata = rval;
    dat_we = dwe; dat_byte = d; fifo_full = full;
    // model update per R3..R9
    if (acc) begin
      m_eop = 0; m_abt = 0;
      if (m_cnt == 1) m_cnt = m_rpt ? m_len : 0;
      else if (m_cnt != 0) m_cnt = m_cnt - 1;
    end
    if (rwe && !radr) begin
      m_eop = rval[0]; m_abt = rval[1]; m_rpt = rval[2];
      if (rval[3]) m_ovf = 0;
    end
    if (rwe && radr) begin
      m_len = rval; m_cnt = rval;
    end
    if (dwe && full) m_ovf = 1;
    @(negedge clk);
    reg_we = 0; dat_we = 0; fifo_full = 0;
    check(push_vld == acc, req, "push_vld", int'(push_vld), int'(acc));
    check(int'(push_entry) == ee, req, "push_entry", int'(push_entry), ee);
    check(overflow == m_ovf, req, "overflow", int'(overflow), int'(m_ovf));
  endtask

  task automatic wr(input logic [7:0] d, input string req);
    op(0, 0, 16'd0, 1, d, 0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check(push_vld == 0, "R1", "push_vld", int'(push_vld), 0);
    check(push_entry == 0, "R1", "push_entry", int'(push_entry), 0);
    check(overflow == 0, "R1", "overflow", int'(overflow), 0);
    wr(8'h5A, "R1_tags_and_count_clear");
    // R2: plain bytes, no tags
    wr(8'hAA, "R2");
    op(0, 0, 0, 0, 8'hFF, 0, "R2_idle");
    wr(8'h03, "R2");
    // R3: manual end-of-packet, self-clears
    op(1, 0, 16'h0001, 0, 0, 0, "R3");
    wr(8'h77, "R3");
    wr(8'h12, "R3_selfclear");
    // R3: manual abort
    op(1, 0, 16'h0002, 0, 0, 0, "R3");
    wr(8'h34, "R3_abort");
    wr(8'h35, "R3_abort_cleared");
    // R4/R5: length 3, no repeat: tag on third, then none
    op(1, 0, 16'h0000, 0, 0, 0, "R5");
    op(1, 1, 16'd3, 0, 0, 0, "R4");
    for (int i = 0; i < 7; i++) wr(8'(8'h40 + i), "R4_R5_norepeat");
    // R5: length 2 with repeat
    op(1, 0, 16'h0004, 0, 0, 0, "R5");
    op(1, 1, 16'd2, 0, 0, 0, "R5");
    for (int i = 0; i < 6; i++) wr(8'(8'h50 + i), "R5_repeat");
    // length 1 with repeat: every byte tagged
    op(1, 1, 16'd1, 0, 0, 0, "R5");
    for (int i = 0; i < 3; i++) wr(8'(8'h60 + i), "R5_len1");
    // R6: zero count
    op(1, 1, 16'd0, 0, 0, 0, "R6");
    for (int i = 0; i < 4; i++) wr(8'(8'h70 + i), "R6_zero");
    // R7: manual OR counter
    op(1, 0, 16'h0001, 0, 0, 0, "R7");
    op(1, 1, 16'd2, 0, 0, 0, "R7");
    wr(8'h81, "R7_manual_only");
    op(1, 0, 16'h0001, 0, 0, 0, "R7");
    wr(8'h82, "R7_both");
    // R8: full drops, state preserved, overflow sticky then cleared
    op(1, 0, 16'h0000, 0, 0, 0, "R8");
    op(1, 1, 16'd2, 0, 0, 0, "R8");
    op(1, 0, 16'h0002, 0, 0, 0, "R8");
    op(0, 0, 0, 1, 8'h90, 1, "R8_drop");
    op(0, 0, 0, 1, 8'h91, 1, "R8_drop");
    wr(8'h92, "R8_tags_kept");
    wr(8'h93, "R8_count_kept");
    op(1, 0, 16'h0008, 1, 8'h94, 1, "R8_set_beats_clear");
    op(1, 0, 16'h0008, 0, 0, 0, "R8_clear");
    // R9: same-cycle control write and data write
    op(1, 0, 16'h0001, 1, 8'hA0, 0, "R9_ctl");
    wr(8'hA1, "R9_ctl_next");
    op(1, 1, 16'd3, 0, 0, 0, "R9");
    wr(8'hA2, "R9");
    wr(8'hA3, "R9");
    op(1, 1, 16'd2, 1, 8'hA4, 0, "R9_load");
    wr(8'hA5, "R9_load_next");
    wr(8'hA6, "R9_load_next");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      bit rwe, radr, dwe, full;
      logic [15:0] v;
      r = $urandom;
      rwe = (r[3:0] < 3);
      radr = r[4];
      dwe = (r[9:8] != 0);
      full = (r[14:12] == 0);
      v = radr ? 16'(r[18:16]) : 16'(r[23:20]);
      op(rwe, radr, v, dwe, 8'($urandom), full, "R2_R4_R7_R8_R9_random");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule